// File: doc/BRIEF.md
# Key-Protected Software Reset Controller

This block gives software a guarded way to reset the chip. It has three 32-bit registers on a simple write/read bus: a cause register, a control register and a configuration register. Writes to control and configuration take effect only after a 16-bit key has been written into the low half of the control register. Once unlocked, one control write carrying the trigger pattern in its upper half starts a reset pulse of fixed length. The configuration register decides whether that pulse is marked as hard or soft.

A power-on reset input also drives the same reset output. The cause register records whether the last reset came from power-on, from a hard software trigger or from a soft one. A software pulse does not clear that record, so boot code can read it and skip work that a warm reset does not need. While the pulse is active, the lock and the configuration go back to their defaults and the bus ignores writes. The bus is plain control and status access with no flow control. A write takes one cycle with `wr_en` high, and `rdata` is a combinational function of `addr`.

Top module: `keyed_reset_ctrl`

## Requirements
- R1: While `por_n` is low, `rst_out` and `rst_hard` are 1. After `por_n` rises, `rst_out` stays high for exactly 16 more samples. After that, cause (0xE4) reads 0x00000001, configuration (0xEC) reads 0x00002000 and control (0xE8) reads 0xFFFF0000.
- R2: While locked, a control write whose bits [15:0] differ from 0x5A69 has no effect: no pulse starts and control bit 0 (unlocked flag) stays 0.
- R3: While locked, a control write whose bits [15:0] equal 0x5A69 sets the unlocked flag (control reads 0xFFFF0001). It starts no pulse, whatever bits [31:16] hold.
- R4: While locked, a configuration write is ignored.
- R5: An unlock is consumed by the first following write to control or configuration, after which the block is locked. Writes to other addresses do not consume it.
- R6: While unlocked, a control write with bits [31:16] = 0xFFFE starts a reset pulse. `rst_out` is high for exactly 16 cycles, starting with the cycle after the write. Any other upper half only relocks.
- R7: Throughout a software pulse, `rst_hard` equals the inverse of configuration bit 13 as it was at the trigger (0 = hard, 1 = soft).
- R8: The cause register is one-hot in bits [2:0]: bit 0 = power-on, bit 1 = hard software, bit 2 = soft software. It is set at the trigger, kept after the pulse, and is read-only.
- R9: During a pulse, bus writes are ignored. At the end of the pulse the block is locked and configuration reads 0x00002000.
- R10: A power-on reset sets the cause register back to 0x00000001, even after a software reset.
- R11: Addresses other than 0xE4, 0xE8 and 0xEC read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| addr | input | 8 | Register byte address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one write per cycle |
| rdata | output | 32 | Read data for `addr` (combinational) |
| rst_out | output | 1 | Reset pulse output |
| rst_hard | output | 1 | High when the active reset is hard |

## Verification
The key check is swept over every single-bit corruption of the key. Each corrupted word also carries the trigger pattern, so a faulty compare that lets one bit slip would either unlock the block or start a pulse. The trigger check is tried with the exact pattern and with a neighbouring upper half, which separates a trigger from a plain relock. Software pulses are run once with hard and once with soft configuration, and with writes injected mid-pulse. This separates the cause encodings and the pulse-type flag, and shows that the defaults are restored. Power-on resets are applied at the start and again after a software reset, to separate a cause that is kept from one that is cleared.

// File: rtl/keyed_reset_pkg.sv
package keyed_reset_pkg;
  localparam int DATA_W = 32;
  localparam int CAUSE_W = 3;
  localparam logic [15:0] TRIG_PATTERN = 16'hFFFE;

  typedef enum logic [1:0] {
    REG_NONE,
    REG_CAUSE,
    REG_CTRL,
    REG_CFG
  } kr_reg_e;

  localparam logic [CAUSE_W-1:0] CAUSE_POR  = 3'b001;
  localparam logic [CAUSE_W-1:0] CAUSE_HARD = 3'b010;
  localparam logic [CAUSE_W-1:0] CAUSE_SOFT = 3'b100;
endpackage

// File: rtl/kr_decode.sv
module kr_decode
  import keyed_reset_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'hE4,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'hE8,
  parameter logic [ADDR_W-1:0] CFG_OFS   = 8'hEC
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              busy,
  output kr_reg_e           sel,
  output logic              ctrl_wr,
  output logic              cfg_wr
);
  always_comb begin
    if (addr == CAUSE_OFS)      sel = REG_CAUSE;
    else if (addr == CTRL_OFS)  sel = REG_CTRL;
    else if (addr == CFG_OFS)   sel = REG_CFG;
    else                        sel = REG_NONE;
  end

  assign ctrl_wr = wr_en && !busy && (sel == REG_CTRL);
  assign cfg_wr  = wr_en && !busy && (sel == REG_CFG);
endmodule

// File: rtl/kr_lock.sv
module kr_lock (
  input  logic clk,
  input  logic por_n,
  input  logic busy,
  input  logic ctrl_wr,
  input  logic cfg_wr,
  input  logic key_ok,
  input  logic trig_ok,
  output logic unlocked,
  output logic trigger,
  output logic cfg_load
);
  // One write to either guarded register spends the unlock.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        unlocked <= 1'b0;
    else if (busy)     unlocked <= 1'b0;
    else if (ctrl_wr)  unlocked <= !unlocked && key_ok;
    else if (cfg_wr)   unlocked <= 1'b0;
  end

  assign trigger  = ctrl_wr && unlocked && trig_ok;
  assign cfg_load = cfg_wr && unlocked;
endmodule

// File: rtl/kr_pulse.sv
module kr_pulse #(
  parameter int PULSE_LEN = 16,
  localparam int CNT_W = $clog2(PULSE_LEN + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic trigger,
  input  logic hard_sel,
  output logic rst_out,
  output logic rst_hard
);
  localparam logic [CNT_W-1:0] LEN = CNT_W'(PULSE_LEN);

  logic [CNT_W-1:0] remain;
  logic             hard_q;

  // Power-on holds the counter full; it drains once por_n is released.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      remain <= LEN;
      hard_q <= 1'b1;
    end else if (trigger) begin
      remain <= LEN;
      hard_q <= hard_sel;
    end else if (remain != '0) begin
      remain <= remain - 1'b1;
    end
  end

  assign rst_out  = (remain != '0);
  assign rst_hard = rst_out && hard_q;
endmodule

// File: rtl/kr_cause.sv
module kr_cause
  import keyed_reset_pkg::*;
(
  input  logic               clk,
  input  logic               por_n,
  input  logic               trigger,
  input  logic               hard_sel,
  output logic [CAUSE_W-1:0] cause
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)        cause <= CAUSE_POR;
    else if (trigger)  cause <= hard_sel ? CAUSE_HARD : CAUSE_SOFT;
  end
endmodule

// File: rtl/keyed_reset_ctrl.sv
module keyed_reset_ctrl
  import keyed_reset_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PULSE_LEN = 16,
  parameter logic [15:0] KEY_VAL = 16'h5A69,
  parameter int SOFT_BIT = 13,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'hE4,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'hE8,
  parameter logic [ADDR_W-1:0] CFG_OFS   = 8'hEC
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rdata,
  output logic              rst_out,
  output logic              rst_hard
);
  kr_reg_e            sel;
  logic               ctrl_wr, cfg_wr;
  logic               unlocked, trigger, cfg_load;
  logic               soft_mode;
  logic [CAUSE_W-1:0] cause;

  kr_decode #(
    .ADDR_W(ADDR_W), .CAUSE_OFS(CAUSE_OFS), .CTRL_OFS(CTRL_OFS), .CFG_OFS(CFG_OFS)
  ) u_dec (
    .addr(addr), .wr_en(wr_en), .busy(rst_out),
    .sel(sel), .ctrl_wr(ctrl_wr), .cfg_wr(cfg_wr)
  );

  kr_lock u_lock (
    .clk(clk), .por_n(por_n), .busy(rst_out),
    .ctrl_wr(ctrl_wr), .cfg_wr(cfg_wr),
    .key_ok(wdata[15:0] == KEY_VAL),
    .trig_ok(wdata[DATA_W-1:16] == TRIG_PATTERN),
    .unlocked(unlocked), .trigger(trigger), .cfg_load(cfg_load)
  );

  // Configuration: soft mode by default, restored while a pulse runs.
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         soft_mode <= 1'b1;
    else if (rst_out)   soft_mode <= 1'b1;
    else if (cfg_load)  soft_mode <= wdata[SOFT_BIT];
  end

  kr_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
    .clk(clk), .por_n(por_n), .trigger(trigger), .hard_sel(!soft_mode),
    .rst_out(rst_out), .rst_hard(rst_hard)
  );

  kr_cause u_cause (
    .clk(clk), .por_n(por_n), .trigger(trigger), .hard_sel(!soft_mode),
    .cause(cause)
  );

  always_comb begin
    rdata = '0;
    case (sel)
      REG_CAUSE: rdata[CAUSE_W-1:0] = cause;
      REG_CTRL: begin
        rdata[DATA_W-1:16] = '1;
        rdata[0] = unlocked;
      end
      REG_CFG: rdata[SOFT_BIT] = soft_mode;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/keyed_reset_ctrl_chk.sv
module keyed_reset_ctrl_chk #(
  parameter int ADDR_W = 8,
  parameter int PULSE_LEN = 16,
  parameter logic [15:0] KEY_VAL = 16'h5A69,
  parameter logic [ADDR_W-1:0] CAUSE_OFS = 8'hE4,
  parameter logic [ADDR_W-1:0] CTRL_OFS  = 8'hE8,
  parameter logic [ADDR_W-1:0] CFG_OFS   = 8'hEC,
  localparam int HW = $clog2(PULSE_LEN + 2) + 1
) (
  input logic              clk,
  input logic              por_n,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       key_bits,
  input logic              wr_en,
  input logic [31:0]       rdata,
  input logic              rst_out,
  input logic              rst_hard,
  input logic              unlocked
);
  logic [HW-1:0] high_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                      high_run <= '0;
    else if (!rst_out)               high_run <= '0;
    else if (high_run != '1)         high_run <= high_run + 1'b1;
  end

  // R6
  pulse_len_chk: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_out && $past(rst_out)) |-> (high_run == HW'(PULSE_LEN)));

  // R7
  hard_flag_stable_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rst_out && $past(rst_out)) |-> $stable(rst_hard));

  // R2
  bad_key_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !rst_out && !unlocked && addr == CTRL_OFS && key_bits != KEY_VAL)
      |=> (!unlocked && !rst_out));

  // R5
  one_shot_unlock_chk: assert property (@(posedge clk) disable iff (!por_n)
    (wr_en && !rst_out && unlocked && (addr == CTRL_OFS || addr == CFG_OFS))
      |=> !unlocked);

  // R8
  cause_onehot_chk: assert property (@(posedge clk) disable iff (!por_n)
    (addr == CAUSE_OFS) |-> ($countones(rdata[2:0]) == 1 && rdata[31:3] == '0));

  // R9
  locked_in_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
    (rst_out && addr == CTRL_OFS) |-> !rdata[0]);
endmodule

bind keyed_reset_ctrl keyed_reset_ctrl_chk #(
  .ADDR_W(ADDR_W), .PULSE_LEN(PULSE_LEN), .KEY_VAL(KEY_VAL),
  .CAUSE_OFS(CAUSE_OFS), .CTRL_OFS(CTRL_OFS), .CFG_OFS(CFG_OFS)
) u_chk (
  .clk(clk), .por_n(por_n), .addr(addr), .key_bits(wdata[15:0]),
  .wr_en(wr_en), .rdata(rdata), .rst_out(rst_out), .rst_hard(rst_hard),
  .unlocked(unlocked)
);

// File: tb/keyed_reset_ctrl_tb.sv
module keyed_reset_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_CAUSE = 8'hE4;
  localparam logic [7:0] A_CTRL  = 8'hE8;
  localparam logic [7:0] A_CFG   = 8'hEC;
  localparam logic [15:0] KEY = 16'h5A69;

  logic        clk = 1'b0;
  logic        por_n = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic [31:0] rdata;
  logic        rst_out, rst_hard;

  int ntests = 0;
  int nfail = 0;
  int cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  keyed_reset_ctrl u_dut (
    .clk(clk), .por_n(por_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rdata(rdata), .rst_out(rst_out), .rst_hard(rst_hard)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      nfail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", ntests, nfail);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    ntests++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input string req, input logic [7:0] a, input logic [31:0] exp);
    addr = a;
    #1;
    check(req, rdata, exp);
  endtask

  // Counts negedge samples with rst_out high; optionally injects writes.
  task automatic measure(input string req, input logic exp_hard, input bit inject);
    int n = 0;
    logic hard_ok = 1'b1;
    while (rst_out && n < 64) begin
      if (rst_hard !== exp_hard) hard_ok = 1'b0;
      n++;
      if (inject && n == 2) begin addr = A_CTRL; wdata = {16'hFFFF, KEY}; wr_en = 1'b1; end
      if (inject && n == 3) begin addr = A_CFG;  wdata = 32'h0; wr_en = 1'b1; end
      if (inject && n == 4) begin addr = A_CAUSE; wdata = 32'h0; wr_en = 1'b1; end
      if (inject && n == 5) wr_en = 1'b0;
      @(negedge clk);
    end
    wr_en = 1'b0;
    check({req, " pulse length"}, 32'(n), 32'd16);
    check({req, " hard flag"}, {31'b0, hard_ok}, 32'd1);
  endtask

  initial begin
    // R1: power-on
    repeat (3) @(negedge clk);
    check("R1 rst_out in por", {31'b0, rst_out}, 32'd1);
    check("R1 rst_hard in por", {31'b0, rst_hard}, 32'd1);
    por_n = 1'b1;
    measure("R1", 1'b1, 1'b0);
    rd("R1 cause", A_CAUSE, 32'h1);
    rd("R1 cfg", A_CFG, 32'h2000);
    rd("R1 ctrl", A_CTRL, 32'hFFFF0000);

    // R2: every single-bit key corruption, with trigger pattern attached
    for (int i = 0; i < 16; i++) begin
      wr(A_CTRL, {16'hFFFE, KEY ^ (16'h1 << i)});
      check("R2 no pulse", {31'b0, rst_out}, 32'd0);
      rd("R2 still locked", A_CTRL, 32'hFFFF0000);
    end

    // R4: locked configuration write
    wr(A_CFG, 32'h0);
    rd("R4 cfg kept", A_CFG, 32'h2000);

    // R3: key with trigger bits does not start a pulse
    wr(A_CTRL, {16'hFFFE, KEY});
    check("R3 no pulse", {31'b0, rst_out}, 32'd0);
    rd("R3 unlocked", A_CTRL, 32'hFFFF0001);

    // R11 / R5: unmapped and cause writes do not consume unlock
    wr(8'h00, 32'hFFFE0000);
    wr(A_CAUSE, 32'h0);
    rd("R11 unmapped read", 8'h00, 32'h0);
    rd("R11 unmapped read hi", 8'hF0, 32'h0);
    rd("R8 cause read-only", A_CAUSE, 32'h1);
    rd("R5 still unlocked", A_CTRL, 32'hFFFF0001);

    // R6: non-trigger upper half only relocks
    wr(A_CTRL, 32'hFFFC0000);
    check("R6 no pulse", {31'b0, rst_out}, 32'd0);
    rd("R5 relocked by ctrl", A_CTRL, 32'hFFFF0000);

    // R5: config write spends unlock
    wr(A_CTRL, {16'hFFFF, KEY});
    wr(A_CFG, 32'h0);
    rd("R5 cfg took hard", A_CFG, 32'h0);
    rd("R5 relocked by cfg", A_CTRL, 32'hFFFF0000);
    wr(A_CFG, 32'h2000);
    rd("R4 cfg ignored", A_CFG, 32'h0);

    // R6/R7/R8/R9: hard software pulse with injected writes
    wr(A_CTRL, {16'hFFFF, KEY});
    wr(A_CTRL, 32'hFFFE0000);
    measure("R6 R7 hard", 1'b1, 1'b1);
    rd("R8 cause hard", A_CAUSE, 32'h2);
    rd("R9 cfg default", A_CFG, 32'h2000);
    rd("R9 locked after", A_CTRL, 32'hFFFF0000);

    // R7/R8: soft software pulse
    wr(A_CTRL, {16'hFFFF, KEY});
    wr(A_CTRL, 32'hFFFE0000);
    measure("R6 R7 soft", 1'b0, 1'b0);
    rd("R8 cause soft", A_CAUSE, 32'h4);

    // R10: power-on after software reset
    @(negedge clk);
    por_n = 1'b0;
    repeat (2) @(negedge clk);
    por_n = 1'b1;
    measure("R10", 1'b1, 1'b0);
    rd("R10 cause por", A_CAUSE, 32'h1);

    $display("[TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end
endmodule